// File: doc/BRIEF.md
# SDRAM Command Sequencer with Periodic Refresh

This block turns single read and write requests into commands for a single-data-rate SDRAM. Each request names a bank, a row and a column. For every bank the sequencer records whether a row is open and which row it is. A request that hits the open row goes straight to a column command. A request to a closed bank first opens the row. A request that misses the open row closes that row, then opens the new row, and only then issues the column access.

A free-running refresh timer raises a refresh demand at a fixed interval, derived from the clock frequency. While the demand is pending, requests are stalled. The sequencer closes every open bank with one precharge-all, waits out the precharge time and issues auto-refresh. During the refresh cycle time it drives NOP. A single load-mode command is issued once after reset.

The command pins are registered. A request is taken in the cycle in which `req_ready_o` is high, and its column command appears on the pins one cycle later.

Top module: `sdram_cmd_seq`

## Requirements
- R1: Every cycle the pins {cs_no, ras_no, cas_no, we_no} carry one of the following codes (all active low): activate 0011, precharge 0010, read 0101, write 0100, auto-refresh 0001, load-mode 0000, NOP 0111.
- R2: During reset the pins carry NOP. The first command after reset is load-mode with addr_o equal to MODE_WORD, and it is issued only once.
- R3: A request to a closed bank first issues activate, with the bank on ba_o and the row on addr_o. A read or write is never issued to a closed bank. A column command follows its activate by at least T_RCD cycles.
- R4: A request that hits the open row of its bank issues read (req_write_i=0) or write (req_write_i=1) with no precharge and no activate. The column sits on addr_o[COL_W-1:0] and the auto-precharge flag on addr_o[AP_BIT]. req_ready_o is high in exactly the cycle before that column command appears on the pins.
- R5: A request whose row differs from the open row issues precharge to that bank with addr_o[AP_BIT]=0, then activate, then the column command. No precharge comes earlier than T_RAS cycles after the activate of its bank.
- R6: A command to one bank leaves the open-row state of every other bank unchanged. A later hit to another bank needs no new activate.
- R7: A column command with the auto-precharge flag set closes its bank. The next access to that bank issues activate without a precharge.
- R8: A refresh demand arises every REF_TICKS = CLK_MHZ*REF_NS/1000 cycles. Consecutive auto-refresh commands are therefore REF_TICKS apart, within the few cycles needed to close banks.
- R9: Auto-refresh is issued only when every bank is closed and T_RP has elapsed. If any bank is open, a precharge with addr_o[AP_BIT]=1 (all banks) is issued first.
- R10: While a refresh demand is pending, no request is accepted, including a hit on an open row.
- R11: After auto-refresh, no other command is issued for T_RFC cycles.
- R12: NOP is driven in every cycle in which no other command is issued.
- R13: An activate to a bank comes at least T_RP cycles after that bank was precharged, whether by an explicit precharge, by precharge-all or by auto-precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present, held until accepted |
| req_ready_o | output | 1 | Request accepted this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_autopre_i | input | 1 | Close the row after the column access |
| req_bank_i | input | BANK_W | Bank of the request |
| req_row_i | input | ROW_W | Row of the request |
| req_col_i | input | COL_W | Column of the request |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| ba_o | output | BANK_W | Bank address |
| addr_o | output | ROW_W | Row, column or mode address |

## Verification
The hardest case to reach is a refresh demand that falls between an activate and its column command. Another is a demand that arrives while a bank still has to wait out T_RAS before precharge-all is allowed. The stimulus reaches both with a shortened refresh interval and dense random traffic over four banks and only four rows, which mixes hits, misses and auto-precharge closes. Under this traffic refresh demands keep colliding with requests that are part way through. A behavioural reference model predicts the pins on every clock, and an independent bank model watches for column commands to closed banks and for refreshes issued while a bank is open.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sdram_cmd_e;

  typedef enum logic {ST_MODE, ST_RUN} seq_state_e;
endpackage

// File: rtl/sdram_gap_cnt.sv
module sdram_gap_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sdram_refresh_ctl.sv
module sdram_refresh_ctl #(
  parameter int TICKS = 781,
  parameter int T_RFC = 8,
  parameter int CNT_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_issue_i,
  output logic ref_pend_o,
  output logic rfc_busy_o
);
  localparam int TW = $clog2(TICKS + 1);
  localparam logic [TW-1:0] TICK_LAST = TW'(TICKS - 1);

  logic [TW-1:0] tick_q;
  logic          pend_q;
  logic          rfc_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= TICK_LAST;
      pend_q <= 1'b0;
    end else begin
      if (tick_q == '0) tick_q <= TICK_LAST;
      else              tick_q <= tick_q - 1'b1;
      // a new demand wins over the clear
      if (tick_q == '0)     pend_q <= 1'b1;
      else if (ref_issue_i) pend_q <= 1'b0;
    end
  end

  sdram_gap_cnt #(.W(CNT_W)) i_rfc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ref_issue_i),
    .val_i  (CNT_W'(T_RFC - 1)),
    .zero_o (rfc_zero)
  );

  assign ref_pend_o = pend_q;
  assign rfc_busy_o = !rfc_zero;
endmodule

// File: rtl/sdram_bank_state.sv
module sdram_bank_state #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 13
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              act_i,
  input  logic                              pre_i,
  input  logic                              pre_all_i,
  input  logic                              col_close_i,
  input  logic [BANK_W-1:0]                 bank_i,
  input  logic [ROW_W-1:0]                  row_i,
  output logic [NUM_BANKS-1:0]              open_o,
  output logic [NUM_BANKS-1:0][ROW_W-1:0]   rows_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    logic open_q;
    logic [ROW_W-1:0] row_q;

    assign sel = (bank_i == BANK_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_q <= 1'b0;
        row_q  <= '0;
      end else if (act_i && sel) begin
        open_q <= 1'b1;
        row_q  <= row_i;
      end else if (pre_all_i || ((pre_i || col_close_i) && sel)) begin
        open_q <= 1'b0;
      end
    end

    assign open_o[b] = open_q;
    assign rows_o[b] = row_q;
  end
endmodule

// File: rtl/sdram_bank_timers.sv
module sdram_bank_timers #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int CNT_W     = 4,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 6,
  parameter int T_RP      = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 act_i,
  input  logic                 pre_i,
  input  logic                 pre_all_i,
  input  logic                 col_close_i,
  input  logic [BANK_W-1:0]    bank_i,
  output logic [NUM_BANKS-1:0] rcd_ok_o,
  output logic [NUM_BANKS-1:0] ras_ok_o,
  output logic [NUM_BANKS-1:0] rp_ok_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    logic close_ld;
    assign sel      = (bank_i == BANK_W'(b));
    assign close_ld = pre_all_i || ((pre_i || col_close_i) && sel);

    sdram_gap_cnt #(.W(CNT_W)) i_rcd (
      .clk_i (clk_i), .rst_ni (rst_ni), .load_i (act_i && sel),
      .val_i (CNT_W'(T_RCD - 1)), .zero_o (rcd_ok_o[b])
    );
    sdram_gap_cnt #(.W(CNT_W)) i_ras (
      .clk_i (clk_i), .rst_ni (rst_ni), .load_i (act_i && sel),
      .val_i (CNT_W'(T_RAS - 1)), .zero_o (ras_ok_o[b])
    );
    sdram_gap_cnt #(.W(CNT_W)) i_rp (
      .clk_i (clk_i), .rst_ni (rst_ni), .load_i (close_ld),
      .val_i (CNT_W'(T_RP - 1)), .zero_o (rp_ok_o[b])
    );
  end
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int AP_BIT    = 10,
  parameter int CLK_MHZ   = 100,
  parameter int REF_NS    = 7813,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 6,
  parameter int T_RFC     = 8,
  parameter int MODE_WORD = 32'h0032
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic              req_autopre_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  output logic              cs_no,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [BANK_W-1:0] ba_o,
  output logic [ROW_W-1:0]  addr_o
);
  localparam int NUM_BANKS = 1 << BANK_W;
  localparam int REF_TICKS = CLK_MHZ * REF_NS / 1000;
  localparam int T_MAX_A   = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int T_MAX_B   = (T_RAS > T_RFC) ? T_RAS : T_RFC;
  localparam int T_MAX     = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
  localparam int CNT_W     = $clog2(T_MAX + 1);

  seq_state_e state_q, state_d;
  sdram_cmd_e cmd_q, cmd_d;
  logic [BANK_W-1:0] ba_q, ba_d;
  logic [ROW_W-1:0]  addr_q, addr_d;

  logic act, pre, pre_all, col_close, ref_issue;
  logic ref_pend, rfc_busy;
  logic [NUM_BANKS-1:0]            bank_open;
  logic [NUM_BANKS-1:0][ROW_W-1:0] bank_rows;
  logic [NUM_BANKS-1:0]            rcd_ok, ras_ok, rp_ok;
  logic hit;

  sdram_refresh_ctl #(.TICKS(REF_TICKS), .T_RFC(T_RFC), .CNT_W(CNT_W)) i_refresh (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ref_issue_i (ref_issue),
    .ref_pend_o  (ref_pend),
    .rfc_busy_o  (rfc_busy)
  );

  sdram_bank_state #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W)) i_banks (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .act_i       (act),
    .pre_i       (pre),
    .pre_all_i   (pre_all),
    .col_close_i (col_close),
    .bank_i      (req_bank_i),
    .row_i       (req_row_i),
    .open_o      (bank_open),
    .rows_o      (bank_rows)
  );

  sdram_bank_timers #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .CNT_W(CNT_W),
    .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP)
  ) i_timers (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .act_i       (act),
    .pre_i       (pre),
    .pre_all_i   (pre_all),
    .col_close_i (col_close),
    .bank_i      (req_bank_i),
    .rcd_ok_o    (rcd_ok),
    .ras_ok_o    (ras_ok),
    .rp_ok_o     (rp_ok)
  );

  assign hit = bank_open[req_bank_i] && (bank_rows[req_bank_i] == req_row_i);

  always_comb begin
    state_d     = state_q;
    cmd_d       = CMD_NOP;
    ba_d        = '0;
    addr_d      = '0;
    act         = 1'b0;
    pre         = 1'b0;
    pre_all     = 1'b0;
    col_close   = 1'b0;
    ref_issue   = 1'b0;
    req_ready_o = 1'b0;
    if (state_q == ST_MODE) begin
      cmd_d   = CMD_LMR;
      addr_d  = ROW_W'(MODE_WORD);
      state_d = ST_RUN;
    end else if (rfc_busy) begin
      cmd_d = CMD_NOP;
    end else if (ref_pend) begin
      if (|bank_open) begin
        if (&ras_ok) begin
          cmd_d          = CMD_PRE;
          addr_d[AP_BIT] = 1'b1;
          pre_all        = 1'b1;
        end
      end else if (&rp_ok) begin
        cmd_d     = CMD_REF;
        ref_issue = 1'b1;
      end
    end else if (req_valid_i) begin
      if (hit) begin
        if (rcd_ok[req_bank_i] && (!req_autopre_i || ras_ok[req_bank_i])) begin
          cmd_d               = req_write_i ? CMD_WR : CMD_RD;
          ba_d                = req_bank_i;
          addr_d[COL_W-1:0]   = req_col_i;
          addr_d[AP_BIT]      = req_autopre_i;
          col_close           = req_autopre_i;
          req_ready_o         = 1'b1;
        end
      end else if (bank_open[req_bank_i]) begin
        if (ras_ok[req_bank_i]) begin
          cmd_d = CMD_PRE;
          ba_d  = req_bank_i;
          pre   = 1'b1;
        end
      end else if (rp_ok[req_bank_i]) begin
        cmd_d  = CMD_ACT;
        ba_d   = req_bank_i;
        addr_d = req_row_i;
        act    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_MODE;
      cmd_q   <= CMD_NOP;
      ba_q    <= '0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      ba_q    <= ba_d;
      addr_q  <= addr_d;
    end
  end

  assign {cs_no, ras_no, cas_no, we_no} = cmd_q;
  assign ba_o   = ba_q;
  assign addr_o = addr_q;
endmodule

// File: rtl/sdram_cmd_seq_chk.sv
module sdram_cmd_seq_chk #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 13,
  parameter int AP_BIT    = 10
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_ready_o,
  input logic                 cs_no,
  input logic                 ras_no,
  input logic                 cas_no,
  input logic                 we_no,
  input logic [BANK_W-1:0]    ba_o,
  input logic [ROW_W-1:0]     addr_o,
  input logic [NUM_BANKS-1:0] bank_open,
  input logic                 ref_pend
);
  logic [3:0] pins;
  logic [NUM_BANKS-1:0] open_q;
  assign pins = {cs_no, ras_no, cas_no, we_no};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) open_q <= '0;
    else         open_q <= bank_open;
  end

  assert_legal_code_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pins inside {4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b0100, 4'b0101, 4'b0111});

  assert_mode_once_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins == 4'b0000) |=> (pins != 4'b0000));

  assert_col_open_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins == 4'b0101 || pins == 4'b0100) |-> open_q[ba_o]);

  assert_act_closed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins == 4'b0011) |-> !open_q[ba_o]);

  assert_ready_col_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |=> (!cs_no && ras_no && !cas_no));

  assert_pre_open_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins == 4'b0010 && !addr_o[AP_BIT]) |-> open_q[ba_o]);

  assert_ref_closed_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins == 4'b0001) |-> (bank_open == '0));

  assert_pend_blocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_pend |-> !req_ready_o);

  assert_ref_gap_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins == 4'b0001) |=> (pins == 4'b0111));
endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(
  .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W), .AP_BIT(AP_BIT)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .cs_no       (cs_no),
  .ras_no      (ras_no),
  .cas_no      (cas_no),
  .we_no       (we_no),
  .ba_o        (ba_o),
  .addr_o      (addr_o),
  .bank_open   (bank_open),
  .ref_pend    (ref_pend)
);

// File: tb/test_sdram_cmd_seq.sv
module test_sdram_cmd_seq;
  localparam int BANK_W = 2, ROW_W = 13, COL_W = 10, AP_BIT = 10;
  localparam int CLK_MHZ = 100, REF_NS = 2000;
  localparam int T_RCD = 3, T_RP = 3, T_RAS = 6, T_RFC = 8;
  localparam int MODE_WORD = 32'h0032;
  localparam int NB = 4;
  localparam int TICKS = CLK_MHZ * REF_NS / 1000;

  localparam logic [3:0] C_LMR = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                         C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101, C_NOP = 4'b0111;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_autopre = 1'b0;
  logic [BANK_W-1:0] req_bank = '0;
  logic [ROW_W-1:0]  req_row = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic req_ready, cs_n, ras_n, cas_n, we_n;
  logic [BANK_W-1:0] ba;
  logic [ROW_W-1:0]  addr;

  always #5 clk = ~clk;

  sdram_cmd_seq #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .AP_BIT(AP_BIT),
    .CLK_MHZ(CLK_MHZ), .REF_NS(REF_NS), .T_RCD(T_RCD), .T_RP(T_RP),
    .T_RAS(T_RAS), .T_RFC(T_RFC), .MODE_WORD(MODE_WORD)
  ) i_sdram_cmd_seq (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_autopre_i(req_autopre), .req_bank_i(req_bank),
    .req_row_i(req_row), .req_col_i(req_col), .cs_no(cs_n), .ras_no(ras_n),
    .cas_no(cas_n), .we_no(we_n), .ba_o(ba), .addr_o(addr)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act_v, input longint exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act_v, exp_v);
    end
  endtask

  // ---------------- reference model ----------------
  int m_open[NB], m_row[NB], m_rcd[NB], m_ras[NB], m_rp[NB];
  int m_rfc, m_tick;
  bit m_pend, m_mode, m_started, rdy_seen;
  logic [3:0] exp_cmd;
  logic [BANK_W-1:0] exp_ba;
  logic [ROW_W-1:0] exp_addr;
  string exp_tag;
  bit any_open, all_ras, all_rp, is_col;
  int b;

  always @(posedge clk) begin
    if (!rst_ni) begin
      for (int i = 0; i < NB; i++) begin
        m_open[i] = 0; m_row[i] = 0; m_rcd[i] = 0; m_ras[i] = 0; m_rp[i] = 0;
      end
      m_rfc = 0; m_tick = TICKS - 1; m_pend = 0; m_mode = 1;
      exp_cmd = C_NOP; exp_ba = '0; exp_addr = '0; exp_tag = "R2";
      m_started = 1;
    end else begin
      exp_cmd = C_NOP; exp_ba = '0; exp_addr = '0; exp_tag = "R12"; is_col = 0;
      b = int'(req_bank);
      any_open = 0; all_ras = 1; all_rp = 1;
      for (int i = 0; i < NB; i++) begin
        if (m_open[i] != 0) any_open = 1;
        if (m_ras[i] != 0) all_ras = 0;
        if (m_rp[i] != 0) all_rp = 0;
      end
      if (m_mode) begin
        exp_cmd = C_LMR; exp_addr = ROW_W'(MODE_WORD); exp_tag = "R2";
      end else if (m_rfc != 0) begin
        exp_tag = "R11";
      end else if (m_pend) begin
        exp_tag = req_valid ? "R10" : "R9";
        if (any_open) begin
          if (all_ras) begin exp_cmd = C_PRE; exp_addr[AP_BIT] = 1'b1; end
        end else if (all_rp) begin
          exp_cmd = C_REF; exp_tag = "R8";
        end
      end else if (req_valid) begin
        if (m_open[b] != 0 && m_row[b] == int'(req_row)) begin
          exp_tag = "R4";
          if (m_rcd[b] == 0 && (!req_autopre || m_ras[b] == 0)) begin
            exp_cmd = req_write ? C_WR : C_RD; exp_ba = req_bank;
            exp_addr[COL_W-1:0] = req_col; exp_addr[AP_BIT] = req_autopre;
            is_col = 1;
          end
        end else if (m_open[b] != 0) begin
          exp_tag = "R5";
          if (m_ras[b] == 0) begin exp_cmd = C_PRE; exp_ba = req_bank; end
        end else begin
          exp_tag = "R3";
          if (m_rp[b] == 0) begin exp_cmd = C_ACT; exp_ba = req_bank; exp_addr = req_row; end
        end
      end
      chk(is_col == rdy_seen, "R4", "ready", rdy_seen, is_col);
      // state update
      for (int i = 0; i < NB; i++) begin
        if (m_rcd[i] > 0) m_rcd[i]--;
        if (m_ras[i] > 0) m_ras[i]--;
        if (m_rp[i] > 0) m_rp[i]--;
      end
      if (m_rfc > 0) m_rfc--;
      if (exp_cmd == C_LMR) m_mode = 0;
      if (exp_cmd == C_ACT) begin
        m_open[b] = 1; m_row[b] = int'(req_row); m_rcd[b] = T_RCD - 1; m_ras[b] = T_RAS - 1;
      end
      if (exp_cmd == C_PRE && exp_addr[AP_BIT]) begin
        for (int i = 0; i < NB; i++) begin m_open[i] = 0; m_rp[i] = T_RP - 1; end
      end else if (exp_cmd == C_PRE || (is_col && req_autopre)) begin
        m_open[b] = 0; m_rp[b] = T_RP - 1;
      end
      if (exp_cmd == C_REF) m_rfc = T_RFC - 1;
      if (m_tick == 0) begin m_tick = TICKS - 1; m_pend = 1; end
      else begin m_tick--; if (exp_cmd == C_REF) m_pend = 0; end
    end
  end

  // ---------------- pin sampler and bank model ----------------
  int cyc = 0, n_ref = 0, n_act = 0, n_pre = 0, n_col = 0, n_lmr = 0;
  int last_act[NB], last_pre[NB];
  int last_ref = -100000;
  bit bm_open[NB];
  logic [3:0] pins;

  initial for (int i = 0; i < NB; i++) begin
    last_act[i] = -100000; last_pre[i] = -100000; bm_open[i] = 0;
  end

  always @(negedge clk) begin
    #2;
    cyc++;
    rdy_seen = req_ready;
    pins = {cs_n, ras_n, cas_n, we_n};
    if (m_started) begin
      chk(pins == exp_cmd, exp_tag, "cmd", pins, exp_cmd);
      chk(ba == exp_ba, exp_tag, "bank", ba, exp_ba);
      chk(addr == exp_addr, exp_tag, "addr", addr, exp_addr);
    end
    if (rst_ni) begin
      chk(pins inside {C_LMR, C_REF, C_PRE, C_ACT, C_WR, C_RD, C_NOP}, "R1", "code", pins, C_NOP);
      if (pins != C_NOP && pins != C_REF)
        chk(cyc - last_ref >= T_RFC, "R11", "refresh gap", cyc - last_ref, T_RFC);
      case (pins)
        C_LMR: begin
          n_lmr++;
          chk(n_lmr == 1, "R2", "load-mode count", n_lmr, 1);
        end
        C_ACT: begin
          n_act++;
          chk(!bm_open[ba], "R3", "act to open bank", bm_open[ba], 0);
          chk(cyc - last_pre[ba] >= T_RP, "R13", "pre to act", cyc - last_pre[ba], T_RP);
          bm_open[ba] = 1; last_act[ba] = cyc;
        end
        C_RD, C_WR: begin
          n_col++;
          chk(bm_open[ba], "R3", "column to closed bank", bm_open[ba], 1);
          chk(cyc - last_act[ba] >= T_RCD, "R3", "act to column", cyc - last_act[ba], T_RCD);
          if (addr[AP_BIT]) begin
            chk(cyc - last_act[ba] >= T_RAS, "R7", "act to auto-pre", cyc - last_act[ba], T_RAS);
            bm_open[ba] = 0; last_pre[ba] = cyc;
          end
        end
        C_PRE: begin
          n_pre++;
          for (int i = 0; i < NB; i++)
            if ((addr[AP_BIT] || ba == BANK_W'(i)) && bm_open[i]) begin
              chk(cyc - last_act[i] >= T_RAS, "R5", "act to pre", cyc - last_act[i], T_RAS);
              bm_open[i] = 0; last_pre[i] = cyc;
            end else if (addr[AP_BIT] || ba == BANK_W'(i)) begin
              last_pre[i] = cyc;
            end
        end
        C_REF: begin
          for (int i = 0; i < NB; i++) begin
            chk(!bm_open[i], "R9", "refresh with open bank", bm_open[i], 0);
            chk(cyc - last_pre[i] >= T_RP, "R9", "pre to refresh", cyc - last_pre[i], T_RP);
          end
          if (n_ref > 0) begin
            chk(cyc - last_ref <= TICKS + 15, "R8", "refresh interval max", cyc - last_ref, TICKS);
            chk(cyc - last_ref >= TICKS - 15, "R8", "refresh interval min", cyc - last_ref, TICKS);
          end
          n_ref++; last_ref = cyc;
        end
        default: ;
      endcase
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input bit wr, input bit ap, input int bk, input int row, input int col);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_autopre = ap;
    req_bank = BANK_W'(bk); req_row = ROW_W'(row); req_col = COL_W'(col);
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  int a0, p0, c0;

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk({cs_n, ras_n, cas_n, we_n} == C_NOP, "R2", "reset pins", {cs_n, ras_n, cas_n, we_n}, C_NOP);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // closed bank: act then read
    a0 = n_act;
    send(0, 0, 0, 5, 8); #3;
    chk(n_act == a0 + 1, "R3", "act on closed bank", n_act - a0, 1);
    // same-row hit
    a0 = n_act; p0 = n_pre;
    send(1, 0, 0, 5, 16); #3;
    chk(n_act == a0 && n_pre == p0, "R4", "hit extra row cmds", n_act - a0 + n_pre - p0, 0);
    // other bank, then hit on first bank again
    send(0, 0, 1, 9, 3); #3;
    a0 = n_act;
    send(0, 0, 0, 5, 40); #3;
    chk(n_act == a0, "R6", "bank0 row kept", n_act - a0, 0);
    // miss
    a0 = n_act; p0 = n_pre;
    send(0, 0, 0, 7, 2); #3;
    chk(n_act == a0 + 1 && n_pre >= p0 + 1, "R5", "miss pre+act", n_pre - p0, 1);
    // auto-precharge then reopen same row
    send(1, 1, 1, 9, 4); #3;
    a0 = n_act; p0 = n_pre; c0 = n_col;
    send(0, 0, 1, 9, 5); #3;
    chk(n_act == a0 + 1, "R7", "reactivate after auto-pre", n_act - a0, 1);
    chk(n_pre == p0 || n_ref > 0, "R7", "no pre after auto-pre", n_pre - p0, 0);
    chk(n_col == c0 + 1, "R4", "one column cmd", n_col - c0, 1);

    // random dense traffic
    for (int k = 0; k < 400; k++) begin
      send($urandom_range(0, 1), ($urandom_range(0, 5) == 0), $urandom_range(0, 3),
           $urandom_range(0, 3), $urandom_range(0, 1023));
      if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 12)) @(negedge clk);
    end
    repeat (TICKS + 30) @(negedge clk);
    #3;
    chk(n_ref >= cyc / TICKS - 2, "R8", "refresh count", n_ref, cyc / TICKS);
    chk(n_lmr == 1, "R2", "load-mode total", n_lmr, 1);
    finish_run();
  end
endmodule